// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits in front of a byte-addressed storage array and gives it the behaviour of a parallel NOR flash part that is driven by command writes. Every bus write is read as a command byte, a confirm code, a word count or payload data. Which one it is depends on the current write cycle and on the command that is active. The block keeps the active command, a write-cycle state and an 8-bit status register. Bus reads are steered to one of four sources: array contents, status, identification codes or the query table.

Supported operations are single-word program, sector erase, clear status, a lock sequence with confirm, and a buffered multi-word write driven by a count. A write-protect input turns program and erase into error reports. Bus requests take one cycle and are single strobes. Read data comes back registered on the cycle after the request.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode at cycle zero, and the status register holds 0x80.
- R2: Array reads and writes use widths of 1, 2 or 4 bytes (size code 0, 1 or 2). The byte at the request address sits in lane 0 (little-endian) and unused upper lanes read as zero.
- R3: In cycle zero, command 0x10 or 0x40 arms a program. The next write stores its data at its address and width, sets status bit 7 and returns to cycle zero. Reads then return status until array mode is selected again.
- R4: A program attempted while write protect is high leaves the array unchanged and sets status bit 4 as well as bit 7.
- R5: Command 0x20 fills the 64-byte sector that holds the address with 0xFF at once. Under write protect it writes nothing and sets status bit 5. Bit 7 is set in both cases. A following 0xD0 returns to cycle zero, and any other byte returns to array-read mode.
- R6: Command 0x60 followed by 0xD0 or 0x01 sets bit 7 and returns to cycle zero. Any other second byte selects array-read mode. The array is never touched.
- R7: Command 0x70 makes reads return the status byte in every lane of the read width. Both 0x70 and 0x90 leave the cycle at zero, so the next write is decoded as a command.
- R8: After 0x90, a read with word index 0 (address divided by 4) returns 0x89 and index 1 returns 0x18. Any other index returns 0x00. The code is replicated into every lane of the read width.
- R9: After 0x98, a read with word index 0x10, 0x11 or 0x12 returns 0x51, 0x52 or 0x59. Index 0x27 returns the log2 of the array size, and index 0x2C returns 0x01. Writes other than 0xFF keep query mode.
- R10: Command 0x50 clears the status register to 0x00 and selects array-read mode.
- R11: Command 0xE8 starts a buffered write. The next write's low byte is the count. Then count+1 data writes are stored, and after them 0xD0 returns to cycle zero with bit 7 set. Any other byte in that confirm cycle selects array-read mode, and the data already written stays.
- R12: 0xFF, 0xF0, 0x00 and any unknown byte in cycle zero select array-read mode.
- R13: A read request produces rd_valid, with its data, on exactly the following cycle. No other cycle has rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*BUS_BYTES | Write data; low byte is the command or confirm code |
| wp | input | 1 | Write protect |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8*BUS_BYTES | Registered read data |

## Verification
The hardest state to reach is the confirm cycle of a buffered write. It comes only after a count write and exactly count+1 data writes. The count arrives on a wide bus and must be cut to one device byte. The stimulus reaches it with a count word whose bit 8 is set: if the count were not cut, the confirm cycle would never come. It also takes the abort path, where a non-confirm byte in that cycle must leave the data already written visible in array mode. Random program traffic runs with write protect raised at random. This folds the error bits into later status reads that the bench model predicts.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_ARG  = 2'd1,
    CY_DATA = 2'd2,
    CY_CONF = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2,
    SRC_QUERY  = 2'd3
  } src_e;

  localparam logic [7:0] OP_NONE     = 8'h00;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_ERASE_B  = 8'h28;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_ID       = 8'h90;
  localparam logic [7:0] OP_QRY      = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_BUF      = 8'hE8;
  localparam logic [7:0] OP_RDALT    = 8'hF0;
  localparam logic [7:0] OP_RDARR    = 8'hFF;

  localparam int ST_READY   = 7;
  localparam int ST_ERS_ERR = 5;
  localparam int ST_PRG_ERR = 4;

  function automatic src_e src_of(input logic [7:0] c);
    case (c)
      OP_PROG_A, OP_PROG_B, OP_ERASE, OP_ERASE_B,
      OP_CLR, OP_LOCK, OP_STAT, OP_BUF: return SRC_STATUS;
      OP_ID:                            return SRC_ID;
      OP_QRY:                           return SRC_QUERY;
      default:                          return SRC_ARRAY;
    endcase
  endfunction

  function automatic logic idle_op_known(input logic [7:0] c);
    case (c)
      OP_NONE, OP_RDARR, OP_RDALT, OP_PROG_A, OP_PROG_B, OP_ERASE,
      OP_CLR, OP_LOCK, OP_STAT, OP_ID, OP_QRY, OP_BUF: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [7:0]       wr_byte,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wp,
  output cyc_e             cyc_q,
  output logic [7:0]       cmd_q,
  output logic [7:0]       status_q,
  output logic             prog_we,
  output logic             erase_en
);

  cyc_e             cyc_d;
  logic [7:0]       cmd_d;
  logic [7:0]       status_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_array;

  always_comb begin
    cyc_d    = cyc_q;
    cmd_d    = cmd_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    prog_we  = 1'b0;
    erase_en = 1'b0;
    to_array = 1'b0;
    if (wr_fire) begin
      case (cyc_q)
        CY_IDLE: begin
          case (wr_byte)
            OP_NONE, OP_RDARR, OP_RDALT: to_array = 1'b1;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QRY: begin
              cyc_d = CY_ARG;
              cmd_d = wr_byte;
            end
            OP_ERASE: begin
              if (wp) status_d[ST_ERS_ERR] = 1'b1;
              else    erase_en = 1'b1;
              status_d[ST_READY] = 1'b1;
              cyc_d = CY_ARG;
              cmd_d = wr_byte;
            end
            OP_CLR: begin
              status_d = 8'h00;
              to_array = 1'b1;
            end
            OP_STAT, OP_ID: cmd_d = wr_byte;
            OP_BUF: begin
              status_d[ST_READY] = 1'b1;
              cyc_d = CY_ARG;
              cmd_d = wr_byte;
            end
            default: to_array = 1'b1;
          endcase
        end
        CY_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              if (wp) status_d[ST_PRG_ERR] = 1'b1;
              else    prog_we = 1'b1;
              status_d[ST_READY] = 1'b1;
              cyc_d = CY_IDLE;
            end
            OP_ERASE: begin
              if (wr_byte == OP_CONFIRM) begin
                status_d[ST_READY] = 1'b1;
                cyc_d = CY_IDLE;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_LOCK: begin
              if (wr_byte == OP_CONFIRM || wr_byte == OP_LOCK_ALT) begin
                status_d[ST_READY] = 1'b1;
                cyc_d = CY_IDLE;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_BUF: begin
              cnt_d = wr_cnt;
              cyc_d = CY_DATA;
            end
            OP_QRY: if (wr_byte == OP_RDARR) to_array = 1'b1;
            default: to_array = 1'b1;
          endcase
        end
        CY_DATA: begin
          if (cmd_q == OP_BUF) begin
            if (wp) status_d[ST_PRG_ERR] = 1'b1;
            else    prog_we = 1'b1;
            status_d[ST_READY] = 1'b1;
            if (cnt_q == '0) cyc_d = CY_CONF;
            cnt_d = cnt_q - 1'b1;
          end else begin
            to_array = 1'b1;
          end
        end
        default: begin
          if (cmd_q == OP_BUF && wr_byte == OP_CONFIRM) begin
            status_d[ST_READY] = 1'b1;
            cyc_d = CY_IDLE;
          end else begin
            to_array = 1'b1;
          end
        end
      endcase
      if (to_array) begin
        cyc_d = CY_IDLE;
        cmd_d = OP_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CY_IDLE;
      cmd_q    <= OP_NONE;
      status_q <= 8'h80;
      cnt_q    <= '0;
    end else if (wr_fire) begin
      cyc_q    <= cyc_d;
      cmd_q    <= cmd_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 6,
  parameter int BUS_BYTES = 4,
  parameter bit BIG_END   = 1'b0
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic                   erase_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             size,
  input  logic [8*BUS_BYTES-1:0] wdata,
  output logic [8*BUS_BYTES-1:0] rdata
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int SECT_BYTES = 1 << SECT_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] lane_addr [BUS_BYTES];
  logic [BUS_BYTES-1:0] lane_on;
  logic [3:0]        nb;

  assign nb = 4'd1 << size;

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    localparam logic [3:0] LI = 4'(i);
    assign lane_on[i]   = (LI < nb);
    assign lane_addr[i] = BIG_END ? addr + ADDR_W'(nb - LI - 4'd1)
                                  : addr + ADDR_W'(LI);
    assign rdata[8*i +: 8] = lane_on[i] ? mem[lane_addr[i]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int k = 0; k < SECT_BYTES; k++)
        mem[{addr[ADDR_W-1:SECT_W], SECT_W'(k)}] <= 8'hFF;
    end else if (wr_en) begin
      for (int i = 0; i < BUS_BYTES; i++)
        if (lane_on[i]) mem[lane_addr[i]] <= wdata[8*i +: 8];
    end
  end

endmodule

// File: rtl/flash_seq_rdmux.sv
module flash_seq_rdmux
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         BUS_BYTES = 4,
  parameter int         DEV_BYTES = 1,
  parameter logic [7:0] MFR_CODE  = 8'h89,
  parameter logic [7:0] DEV_CODE  = 8'h18
) (
  input  src_e                   src,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             size,
  input  logic [8*BUS_BYTES-1:0] arr_data,
  input  logic [7:0]             status,
  output logic [8*BUS_BYTES-1:0] rdata
);

  localparam int SH = $clog2(BUS_BYTES);

  logic [7:0] idx, id_byte, qry_byte, info;
  logic [3:0] nb;
  logic [8*BUS_BYTES-1:0] rep;

  assign idx = 8'(addr >> SH);
  assign nb  = 4'd1 << size;

  always_comb begin
    case (idx)
      8'h00:   id_byte = MFR_CODE;
      8'h01:   id_byte = DEV_CODE;
      default: id_byte = 8'h00;
    endcase
    case (idx)
      8'h10:   qry_byte = 8'h51;
      8'h11:   qry_byte = 8'h52;
      8'h12:   qry_byte = 8'h59;
      8'h13:   qry_byte = 8'h01;
      8'h27:   qry_byte = 8'(ADDR_W);
      8'h2C:   qry_byte = 8'h01;
      default: qry_byte = 8'h00;
    endcase
    case (src)
      SRC_STATUS: info = status;
      SRC_ID:     info = id_byte;
      SRC_QUERY:  info = qry_byte;
      default:    info = 8'h00;
    endcase
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rep
    localparam logic [3:0] LI = 4'(i);
    if ((i % DEV_BYTES) == 0) begin : g_dev
      assign rep[8*i +: 8] = (LI < nb) ? info : 8'h00;
    end else begin : g_pad
      assign rep[8*i +: 8] = 8'h00;
    end
  end

  assign rdata = (src == SRC_ARRAY) ? arr_data : rep;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         SECT_W    = 6,
  parameter int         BUS_BYTES = 4,
  parameter int         DEV_BYTES = 1,
  parameter bit         BIG_END   = 1'b0,
  parameter logic [7:0] MFR_CODE  = 8'h89,
  parameter logic [7:0] DEV_CODE  = 8'h18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [8*BUS_BYTES-1:0] req_wdata,
  input  logic                   wp,
  output logic                   rd_valid,
  output logic [8*BUS_BYTES-1:0] rd_data
);

  localparam int CNT_W = 8 * DEV_BYTES;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       wr_fire, rd_fire;
  cyc_e       cyc_q;
  logic [7:0] cmd_q, status_q;
  logic       prog_we, erase_en;
  logic [8*BUS_BYTES-1:0] arr_data, mux_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_fire = req_valid &  req_write;
  assign rd_fire = req_valid & ~req_write;

  flash_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_fire  (wr_fire),
    .wr_byte  (req_wdata[7:0]),
    .wr_cnt   (req_wdata[CNT_W-1:0]),
    .wp       (wp),
    .cyc_q    (cyc_q),
    .cmd_q    (cmd_q),
    .status_q (status_q),
    .prog_we  (prog_we),
    .erase_en (erase_en)
  );

  flash_seq_array #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BUS_BYTES(BUS_BYTES), .BIG_END(BIG_END)
  ) u_array (
    .clk      (clk),
    .wr_en    (prog_we),
    .erase_en (erase_en),
    .addr     (req_addr),
    .size     (req_size),
    .wdata    (req_wdata),
    .rdata    (arr_data)
  );

  flash_seq_rdmux #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .DEV_BYTES(DEV_BYTES),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rdmux (
    .src      (src_of(cmd_q)),
    .addr     (req_addr),
    .size     (req_size),
    .arr_data (arr_data),
    .status   (status_q),
    .rdata    (mux_data)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mux_data;
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic [7:0] wr_byte,
  input logic       wp,
  input logic       rd_valid,
  input cyc_e       cyc,
  input logic [7:0] cmd,
  input logic [7:0] status
);

  logic wr, idle_wr, prog_arg;
  assign wr       = req_valid && req_write;
  assign idle_wr  = wr && (cyc == CY_IDLE);
  assign prog_arg = wr && (cyc == CY_ARG) && (cmd == OP_PROG_A || cmd == OP_PROG_B);

  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r7_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && (wr_byte == OP_STAT || wr_byte == OP_ID))
      |=> (cyc == CY_IDLE && cmd == $past(wr_byte)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && wr_byte == OP_CLR) |=> (status == 8'h00 && cmd == OP_NONE));

  a_r3_prog_done: assert property (@(posedge clk) disable iff (!rst_n)
    prog_arg |=> (cyc == CY_IDLE && status[ST_READY]));

  a_r4_prog_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_arg && wp) |=> status[ST_PRG_ERR]);

  a_r5_erase_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && wr_byte == OP_ERASE && wp)
      |=> (status[ST_ERS_ERR] && status[ST_READY]));

  a_r11_conf_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_CONF) |-> (cmd == OP_BUF));

  a_r12_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && !idle_op_known(wr_byte)) |=> (cyc == CY_IDLE && cmd == OP_NONE));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .wr_byte   (req_wdata[7:0]),
  .wp        (wp),
  .rd_valid  (rd_valid),
  .cyc       (cyc_q),
  .cmd       (cmd_q),
  .status    (status_q)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, wp;
  logic [1:0]  req_size;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .wp(wp), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [1024];
  logic [7:0] mst;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_arr(input logic [9:0] a, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int i = 0; i < (1 << s); i++) r[8*i +: 8] = model[10'(a + 10'(i))];
    return r;
  endfunction

  function automatic logic [31:0] rep(input logic [7:0] b, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int i = 0; i < (1 << s); i++) r[8*i +: 8] = b;
    return r;
  endfunction

  task automatic m_prog(input logic [9:0] a, input logic [31:0] d, input logic [1:0] s);
    for (int i = 0; i < (1 << s); i++) model[10'(a + 10'(i))] = d[8*i +: 8];
  endtask

  task automatic m_erase(input logic [9:0] a);
    for (int k = 0; k < 64; k++) model[{a[9:6], 6'(k)}] = 8'hFF;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = s;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
    chk("R13 rd_valid after read", 32'(rd_valid), 32'd1);
  endtask

  task automatic rchk(input string req, input logic [9:0] a, input logic [1:0] s,
                      input logic [31:0] exp);
    logic [31:0] d;
    rd(a, s, d);
    chk(req, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mst = 8'h80;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL all watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] d;
    seed = $urandom(32'h0F1A5C0D);
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0; wp = 0;
    do_reset();

    // R5: erase every sector, leaving via 0xFF in the confirm slot
    for (int s = 0; s < 16; s++) begin
      wr(10'(s * 64), 32'h20, 2'd2);
      wr(10'd0, 32'hFF, 2'd2);
      m_erase(10'(s * 64));
    end

    // R1: a second reset keeps the array and comes up in array mode
    do_reset();
    rchk("R1 array mode after reset", 10'h3C, 2'd2, 32'hFFFFFFFF);
    @(negedge clk);
    chk("R13 rd_valid low when idle", 32'(rd_valid), 32'd0);
    wr(10'd0, 32'h70, 2'd2);
    rchk("R1 status 0x80 after reset", 10'd0, 2'd2, 32'h80808080);
    rchk("R7 status replicated x2", 10'd0, 2'd1, 32'h00008080);

    // R7 + R3: 0x70 left cycle zero, so 0x40 is a command
    wr(10'd0, 32'h40, 2'd2);
    wr(10'h40, 32'h11223344, 2'd2); m_prog(10'h40, 32'h11223344, 2'd2);
    rchk("R3 status after program", 10'h40, 2'd2, rep(mst, 2'd2));
    wr(10'd0, 32'hFF, 2'd2);
    rchk("R2 word read", 10'h40, 2'd2, 32'h11223344);
    rchk("R2 byte read", 10'h41, 2'd0, 32'h00000033);
    rchk("R2 half read", 10'h42, 2'd1, 32'h00001122);

    // R4: protected program
    wp = 1'b1;
    wr(10'd0, 32'h10, 2'd2);
    wr(10'h80, 32'hA5, 2'd0);
    mst = mst | 8'h90;
    rchk("R4 program error bit", 10'd0, 2'd2, rep(mst, 2'd2));
    wp = 1'b0;
    wr(10'd0, 32'hFF, 2'd2);
    rchk("R4 array unchanged", 10'h80, 2'd0, 32'h000000FF);

    // R10: clear status
    wr(10'd0, 32'h50, 2'd2); mst = 8'h00;
    rchk("R10 array mode after clear", 10'h40, 2'd2, 32'h11223344);
    wr(10'd0, 32'h70, 2'd2);
    rchk("R10 status cleared", 10'd0, 2'd2, 32'h00000000);

    // R5: erase with confirm
    wr(10'd0, 32'h10, 2'd2);
    wr(10'h9A, 32'h5C, 2'd0); m_prog(10'h9A, 32'h5C, 2'd0); mst = 8'h80;
    wr(10'h9A, 32'h20, 2'd2); m_erase(10'h9A);
    wr(10'd0, 32'hD0, 2'd2);
    rchk("R5 status after confirm", 10'd0, 2'd2, rep(mst, 2'd2));
    wr(10'd0, 32'hFF, 2'd2);
    rchk("R5 sector erased", 10'h98, 2'd2, 32'hFFFFFFFF);
    // R5: protected erase, then a bad second byte
    wr(10'd0, 32'h10, 2'd2);
    wr(10'hC4, 32'h77, 2'd0); m_prog(10'hC4, 32'h77, 2'd0);
    wp = 1'b1;
    wr(10'hC4, 32'h20, 2'd2); mst = mst | 8'hA0;
    rchk("R5 erase error bit", 10'd0, 2'd2, rep(mst, 2'd2));
    wp = 1'b0;
    wr(10'd0, 32'h33, 2'd2);
    rchk("R5 protected sector kept, bad byte exits", 10'hC4, 2'd0, 32'h00000077);

    // R6: lock sequences
    wr(10'd0, 32'h60, 2'd2); wr(10'd0, 32'h01, 2'd2);
    rchk("R6 lock 0x01 confirm", 10'd0, 2'd2, rep(mst, 2'd2));
    wr(10'd0, 32'h60, 2'd2); wr(10'd0, 32'hD0, 2'd2);
    rchk("R6 lock 0xD0 confirm", 10'd0, 2'd2, rep(mst, 2'd2));
    wr(10'd0, 32'h60, 2'd2); wr(10'd0, 32'h55, 2'd2);
    rchk("R6 bad lock byte gives array", 10'h40, 2'd2, 32'h11223344);

    // R8: identification
    wr(10'd0, 32'h90, 2'd2);
    rchk("R8 manufacturer", 10'd0, 2'd2, 32'h89898989);
    rchk("R8 device", 10'd4, 2'd2, 32'h18181818);
    rchk("R8 other index", 10'd8, 2'd2, 32'h00000000);
    rchk("R8 byte width", 10'd0, 2'd0, 32'h00000089);
    wr(10'd0, 32'h10, 2'd2);
    wr(10'h200, 32'hBEEF, 2'd1); m_prog(10'h200, 32'hBEEF, 2'd1);
    wr(10'd0, 32'hFF, 2'd2);
    rchk("R7 0x90 no advance", 10'h200, 2'd1, 32'h0000BEEF);

    // R9: query
    wr(10'd0, 32'h98, 2'd2);
    rchk("R9 Q", 10'h40, 2'd0, 32'h00000051);
    rchk("R9 R", 10'h44, 2'd0, 32'h00000052);
    wr(10'd0, 32'h00, 2'd2);
    rchk("R9 stays in query", 10'h48, 2'd2, 32'h59595959);
    rchk("R9 size code", 10'h9C, 2'd0, 32'h0000000A);
    rchk("R9 region count", 10'hB0, 2'd0, 32'h00000001);
    wr(10'd0, 32'hFF, 2'd2);
    rchk("R9 0xFF leaves query", 10'h40, 2'd2, 32'h11223344);

    // R11: buffered write, count word with bit 8 set must be cut to a byte
    wr(10'h100, 32'hE8, 2'd2);
    wr(10'h100, 32'h103, 2'd2);
    for (int k = 0; k < 4; k++) begin
      wr(10'(10'h100 + 10'(4 * k)), 32'hA0B0C000 + 32'(k), 2'd2);
      m_prog(10'(10'h100 + 10'(4 * k)), 32'hA0B0C000 + 32'(k), 2'd2);
    end
    wr(10'd0, 32'hD0, 2'd2);
    rchk("R11 status after confirm", 10'd0, 2'd2, rep(mst, 2'd2));
    wr(10'd0, 32'hFF, 2'd2);
    for (int k = 0; k < 4; k++)
      rchk("R11 buffered data", 10'(10'h100 + 10'(4 * k)), 2'd2, 32'hA0B0C000 + 32'(k));
    wr(10'h120, 32'hE8, 2'd2);
    wr(10'h120, 32'h00, 2'd2);
    wr(10'h120, 32'hCAFEF00D, 2'd2); m_prog(10'h120, 32'hCAFEF00D, 2'd2);
    wr(10'd0, 32'h77, 2'd2);
    rchk("R11 abort keeps data, array mode", 10'h120, 2'd2, 32'hCAFEF00D);

    // R12: unknown command
    wr(10'd0, 32'h70, 2'd2);
    wr(10'd0, 32'h33, 2'd2);
    rchk("R12 unknown gives array", 10'h40, 2'd2, 32'h11223344);
    wr(10'd0, 32'h70, 2'd2);
    wr(10'd0, 32'hF0, 2'd2);
    rchk("R12 0xF0 gives array", 10'h42, 2'd1, 32'h00001122);

    // Random program traffic with random protection
    wr(10'd0, 32'h50, 2'd2); mst = 8'h00;
    for (int it = 0; it < 300; it++) begin
      logic [1:0]  s;
      logic [9:0]  a, ra;
      logic [31:0] dv;
      logic        w;
      s  = 2'($urandom % 3);
      a  = 10'($urandom) & ~10'((1 << s) - 1);
      dv = $urandom;
      w  = ($urandom % 5) == 0;
      wp = w;
      wr(10'd0, ($urandom % 2) ? 32'h10 : 32'h40, 2'd2);
      wr(a, dv, s);
      mst = mst | 8'h80 | (w ? 8'h10 : 8'h00);
      if (!w) m_prog(a, dv, s);
      wp = 1'b0;
      rchk("R3/R4 random status", 10'($urandom), 2'd2, rep(mst, 2'd2));
      wr(10'd0, 32'hFF, 2'd2);
      rchk("R2 random readback", a, s, m_arr(a, s));
      ra = 10'($urandom) & ~10'd3;
      rchk("R2 random word", ra, 2'd2, m_arr(ra, 2'd2));
      if (it % 50 == 49) begin
        wr(10'd0, 32'h50, 2'd2); mst = 8'h00;
      end
    end

    finished = 1'b1;
    summary();
  end

endmodule